// File: doc/BRIEF.md
# Paper Tape Frame Word Assembler

This block turns the 8-bit frames delivered by a paper tape reader into data words for a processor I/O register. A start command arms the reader, picks a read mode and notes two options: whether the processor wants a completion pulse, and whether it is stalled waiting for the result. In alpha mode the first frame ends the read, and the whole frame becomes the result. In binary mode, frames without the marker hole in bit 7 are skipped. The low six bits of each marked frame are shifted into an 18-bit word, and the third marked frame ends the read.

A read that was started with a completion pulse ends in a direct load and restart. The block pulses `restart_o`, which tells the processor to copy `buf_o` into its I/O register and resume, and it leaves the done flag clear. A read without the pulse ends by setting the done flag and pulsing an interrupt request. Software then collects the word with a read-buffer command, which clears the flag. An alpha-mode start that arrives while the reader is running acts as a stop and has no other effect. End of tape aborts the read. If the processor was waiting, it is released so that it cannot hang.

Top module: `tape_word_asm`

## Requirements
- R1: After reset, `buf_o` is 0 and `done_flag_o`, `running_o`, `irq_o`, `restart_o` and `hold_release_o` are all 0.
- R2: In alpha mode (`start_bin_i`=0), the first frame accepted after the start ends the read. `buf_o` then holds that frame zero-extended to 18 bits.
- R3: In binary mode (`start_bin_i`=1), a frame with bit 7 clear is ignored. It leaves `buf_o` unchanged and does not count toward the three frames.
- R4: In binary mode, the read ends on the third frame with bit 7 set. Frame bits 5:0 fill `buf_o` with the first frame in bits 17:12, the second in bits 11:6 and the third in bits 5:0. Bit 6 is discarded.
- R5: An accepted start command clears `buf_o` to 0 and sets `running_o`, effective on the next clock edge.
- R6: When a read started with `start_cpl_i`=1 ends, `restart_o` pulses for one cycle in the cycle after the final frame. `done_flag_o` is 0 and `irq_o` stays 0.
- R7: When a read started with `start_cpl_i`=0 ends, `done_flag_o` becomes 1 and `irq_o` pulses for one cycle, in the cycle after the final frame. `restart_o` stays 0.
- R8: A start with `start_bin_i`=0 while `running_o`=1 only stops the reader: `running_o` drops and `buf_o` and `done_flag_o` are unchanged. A start with `start_bin_i`=1 while running starts a fresh read.
- R9: `rd_buf_i` clears `done_flag_o` on the next edge and leaves `buf_o` unchanged. A completion in the same cycle takes priority.
- R10: `eot_i` while running stops the reader. If the read was started with `start_wait_i`=1, `hold_release_o` pulses for one cycle. Otherwise it stays 0.
- R11: While `running_o`=0, frames are ignored: `buf_o`, `done_flag_o`, `irq_o` and `restart_o` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start (or alpha stop) command strobe |
| start_bin_i | input | 1 | Mode with start: 1 binary, 0 alpha |
| start_cpl_i | input | 1 | Completion pulse requested with start |
| start_wait_i | input | 1 | Processor waits on this read |
| frame_vld_i | input | 1 | Frame strobe from reader |
| frame_i | input | 8 | Tape frame, bit 7 is the binary marker |
| eot_i | input | 1 | End of tape / reader error |
| rd_buf_i | input | 1 | Read-buffer command, clears done flag |
| buf_o | output | 18 | Assembled buffer |
| done_flag_o | output | 1 | Data waiting status flag |
| irq_o | output | 1 | Interrupt request pulse |
| restart_o | output | 1 | Load I/O register from buf_o and restart pulse |
| hold_release_o | output | 1 | Release of a waiting processor after abort |
| running_o | output | 1 | Reader running |

## Verification
Alpha mode is swept over all 256 frame values, alternating the completion option on each read. This separates a clean 8-bit load from truncation, and it separates the restart path from the flag-and-interrupt path. Binary mode is swept over 64 payload triples, with an unmarked frame of varying content ahead of each marked one. That shows whether skipped frames are kept out of the count and the data, and whether the slots land in order. Directed sequences cover an alpha stop in the middle of a read, a binary restart, frames sent while idle, and end of tape with and without a waiting processor.

// File: rtl/tape_asm_pkg.sv
package tape_asm_pkg;
    localparam int FRAME_W  = 8;
    localparam int PAY_W    = 6;
    localparam int SLOTS    = 3;
    localparam int MARK_BIT = 7;
    localparam int WORD_W   = PAY_W * SLOTS;

    typedef enum logic {
        RD_ALPHA  = 1'b0,
        RD_BINARY = 1'b1
    } rd_mode_e;

    typedef struct packed {
        logic     running;
        rd_mode_e mode;
        logic     waiting;
        logic     cpl;
    } rd_ctl_t;

    typedef struct packed {
        logic take;
        logic last;
    } frame_ev_t;

    // shift one payload into the low end of the word
    function automatic logic [WORD_W-1:0] pack_append(
        input logic [WORD_W-1:0] w,
        input logic [PAY_W-1:0]  p
    );
        return {w[WORD_W-PAY_W-1:0], p};
    endfunction
endpackage

// File: rtl/tape_frame_gate.sv
module tape_frame_gate
    import tape_asm_pkg::*;
#(
    parameter int FW    = FRAME_W,
    parameter int SL    = SLOTS,
    parameter int MARK  = MARK_BIT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          active,
    input  rd_mode_e      mode,
    input  logic          frame_vld,
    input  logic [FW-1:0] frame,
    output frame_ev_t     ev
);
    localparam int CW = (SL > 1) ? $clog2(SL) : 1;
    localparam logic [CW-1:0] LAST_SLOT = CW'(SL - 1);

    logic [CW-1:0] slot_q;
    logic          marked;

    always_comb begin
        marked  = frame[MARK];
        ev.take = active && frame_vld && ((mode == RD_ALPHA) || marked);
        ev.last = ev.take && ((mode == RD_ALPHA) || (slot_q == LAST_SLOT));
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            slot_q <= '0;
        end else if (ev.take && (mode == RD_BINARY)) begin
            if (ev.last) slot_q <= '0;
            else         slot_q <= slot_q + CW'(1);
        end
    end
endmodule

// File: rtl/tape_word_pack.sv
module tape_word_pack
    import tape_asm_pkg::*;
#(
    parameter int FW = FRAME_W,
    parameter int PW = PAY_W,
    parameter int WW = WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          take,
    input  rd_mode_e      mode,
    input  logic [FW-1:0] frame,
    output logic [WW-1:0] word
);
    logic [WW-1:0] alpha_word;

    generate
        if (WW >= FW) begin : g_wide
            assign alpha_word = WW'(frame);
        end else begin : g_narrow
            assign alpha_word = frame[WW-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            word <= '0;
        end else if (take) begin
            if (mode == RD_ALPHA) word <= alpha_word;
            else                  word <= pack_append(word, frame[PW-1:0]);
        end
    end
endmodule

// File: rtl/tape_done_ctrl.sv
module tape_done_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic finish,
    input  logic cpl,
    input  logic abort_wait,
    input  logic rd_buf,
    output logic done_flag,
    output logic irq,
    output logic restart,
    output logic hold_release
);
    always_ff @(posedge clk) begin
        if (rst) begin
            done_flag    <= 1'b0;
            irq          <= 1'b0;
            restart      <= 1'b0;
            hold_release <= 1'b0;
        end else begin
            irq          <= finish && !cpl;
            restart      <= finish && cpl;
            hold_release <= abort_wait;
            if (finish)      done_flag <= !cpl;
            else if (rd_buf) done_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/tape_word_asm.sv
module tape_word_asm
    import tape_asm_pkg::*;
#(
    parameter int FW = FRAME_W,
    parameter int PW = PAY_W,
    parameter int SL = SLOTS,
    parameter int MB = MARK_BIT,
    localparam int WW = PW * SL
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          start_bin_i,
    input  logic          start_cpl_i,
    input  logic          start_wait_i,
    input  logic          frame_vld_i,
    input  logic [FW-1:0] frame_i,
    input  logic          eot_i,
    input  logic          rd_buf_i,
    output logic [WW-1:0] buf_o,
    output logic          done_flag_o,
    output logic          irq_o,
    output logic          restart_o,
    output logic          hold_release_o,
    output logic          running_o
);
    rd_ctl_t   ctl_q;
    frame_ev_t ev;
    logic      start_act, stop_act, eot_act, gate_active, abort_wait;

    always_comb begin
        start_act   = start_i && (start_bin_i || !ctl_q.running);
        stop_act    = start_i && !start_bin_i && ctl_q.running;
        eot_act     = eot_i && ctl_q.running && !start_i;
        gate_active = ctl_q.running && !start_i && !eot_i;
        abort_wait  = eot_act && ctl_q.waiting;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{running: 1'b0, mode: RD_ALPHA, waiting: 1'b0, cpl: 1'b0};
        end else if (start_act) begin
            ctl_q.running <= 1'b1;
            ctl_q.mode    <= start_bin_i ? RD_BINARY : RD_ALPHA;
            ctl_q.waiting <= start_wait_i;
            ctl_q.cpl     <= start_cpl_i;
        end else if (stop_act) begin
            ctl_q.running <= 1'b0;
        end else if (eot_act || ev.last) begin
            ctl_q.running <= 1'b0;
            ctl_q.waiting <= 1'b0;
            ctl_q.cpl     <= 1'b0;
        end
    end

    tape_frame_gate #(.FW(FW), .SL(SL), .MARK(MB)) gate_i (
        .clk       (clk),
        .rst       (rst),
        .clear     (start_i),
        .active    (gate_active),
        .mode      (ctl_q.mode),
        .frame_vld (frame_vld_i),
        .frame     (frame_i),
        .ev        (ev)
    );

    tape_word_pack #(.FW(FW), .PW(PW), .WW(WW)) pack_i (
        .clk   (clk),
        .rst   (rst),
        .clear (start_act),
        .take  (ev.take),
        .mode  (ctl_q.mode),
        .frame (frame_i),
        .word  (buf_o)
    );

    tape_done_ctrl done_i (
        .clk          (clk),
        .rst          (rst),
        .finish       (ev.last),
        .cpl          (ctl_q.cpl),
        .abort_wait   (abort_wait),
        .rd_buf       (rd_buf_i),
        .done_flag    (done_flag_o),
        .irq          (irq_o),
        .restart      (restart_o),
        .hold_release (hold_release_o)
    );

    assign running_o = ctl_q.running;
endmodule

// File: rtl/tape_word_asm_chk.sv
module tape_word_asm_chk #(
    parameter int WW = 18
) (
    input logic          clk,
    input logic          rst,
    input logic          start_i,
    input logic          start_bin_i,
    input logic          rd_buf_i,
    input logic [WW-1:0] buf_o,
    input logic          done_flag_o,
    input logic          irq_o,
    input logic          restart_o,
    input logic          hold_release_o,
    input logic          running_o
);
    assert_restart_no_flag_R6: assert property (@(posedge clk) disable iff (rst)
        restart_o |-> (!done_flag_o && !irq_o));

    assert_irq_sets_flag_R7: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> done_flag_o);

    assert_start_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (start_i && (start_bin_i || !running_o)) |=> (buf_o == '0 && running_o));

    assert_alpha_stop_R8: assert property (@(posedge clk) disable iff (rst)
        (start_i && !start_bin_i && running_o) |=> (!running_o && $stable(buf_o)));

    assert_rdbuf_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_buf_i && !start_i) |=> (!done_flag_o || irq_o));

    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
        hold_release_o |-> !running_o);

    assert_idle_stable_R11: assert property (@(posedge clk) disable iff (rst)
        (!running_o && !start_i) |=> ($stable(buf_o) && !irq_o && !restart_o));
endmodule

bind tape_word_asm tape_word_asm_chk #(.WW(WW)) chk_i (
    .clk            (clk),
    .rst            (rst),
    .start_i        (start_i),
    .start_bin_i    (start_bin_i),
    .rd_buf_i       (rd_buf_i),
    .buf_o          (buf_o),
    .done_flag_o    (done_flag_o),
    .irq_o          (irq_o),
    .restart_o      (restart_o),
    .hold_release_o (hold_release_o),
    .running_o      (running_o)
);

// File: tb/tape_word_asm_tb.sv
`timescale 1ns/1ps
module tape_word_asm_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        start_i, start_bin_i, start_cpl_i, start_wait_i;
    logic        frame_vld_i, eot_i, rd_buf_i;
    logic [7:0]  frame_i;
    logic [17:0] buf_o;
    logic        done_flag_o, irq_o, restart_o, hold_release_o, running_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tape_word_asm dut_i (
        .clk(clk), .rst(rst),
        .start_i(start_i), .start_bin_i(start_bin_i),
        .start_cpl_i(start_cpl_i), .start_wait_i(start_wait_i),
        .frame_vld_i(frame_vld_i), .frame_i(frame_i),
        .eot_i(eot_i), .rd_buf_i(rd_buf_i),
        .buf_o(buf_o), .done_flag_o(done_flag_o), .irq_o(irq_o),
        .restart_o(restart_o), .hold_release_o(hold_release_o),
        .running_o(running_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic do_start(input logic bin, input logic cpl, input logic wt);
        start_i = 1'b1; start_bin_i = bin; start_cpl_i = cpl; start_wait_i = wt;
        cyc();
        start_i = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] f);
        frame_vld_i = 1'b1; frame_i = f;
        cyc();
        frame_vld_i = 1'b0;
    endtask

    task automatic completion(input string tag, input logic cpl);
        check({tag, " restart"}, restart_o, cpl);
        check({tag, " irq"}, irq_o, !cpl);
        check({tag, " flag"}, done_flag_o, !cpl);
        check({tag, " running"}, running_o, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        start_i = 0; start_bin_i = 0; start_cpl_i = 0; start_wait_i = 0;
        frame_vld_i = 0; frame_i = '0; eot_i = 0; rd_buf_i = 0;
        cyc(); cyc();
        rst = 1'b0;
        cyc();
        // R1 reset state
        check("R1 buf", buf_o, 0);
        check("R1 flag", done_flag_o, 0);
        check("R1 running", running_o, 0);
        check("R1 pulses", {irq_o, restart_o, hold_release_o}, 0);

        // R11 frame while idle
        send_frame(8'hC5);
        check("R11 idle buf", buf_o, 0);
        check("R11 idle irq", {irq_o, restart_o, done_flag_o}, 0);

        // R2 / R6 / R7 / R9: alpha sweep over every frame value
        for (int f = 0; f < 256; f++) begin
            logic cpl;
            cpl = f[0];
            do_start(1'b0, cpl, 1'b0);
            check("R5 alpha start buf", buf_o, 0);
            check("R5 alpha running", running_o, 1);
            send_frame(8'(f));
            check("R2 alpha buf", buf_o, 32'(f));
            completion(cpl ? "R6 alpha" : "R7 alpha", cpl);
            rd_buf_i = 1'b1;
            cyc();
            rd_buf_i = 1'b0;
            check("R9 flag cleared", done_flag_o, 0);
            check("R9 buf kept", buf_o, 32'(f));
        end

        // R3 / R4 binary sweep with unmarked frames interleaved
        for (int i = 0; i < 64; i++) begin
            logic [5:0] p0, p1, p2;
            logic       cpl;
            p0 = 6'(i);
            p1 = 6'((i * 5 + 3) & 63);
            p2 = ~6'(i);
            cpl = i[1];
            do_start(1'b1, cpl, 1'b0);
            send_frame({1'b0, 7'(i * 3 + 1)});
            check("R3 skip buf", buf_o, 0);
            check("R3 skip running", running_o, 1);
            send_frame({1'b1, i[2], p0});
            send_frame({1'b0, 7'(i ^ 7'h55)});
            check("R3 skip mid buf", buf_o, 32'(p0));
            send_frame({1'b1, i[3], p1});
            check("R4 partial buf", buf_o, 32'({p0, p1}));
            check("R4 partial no done", {irq_o, restart_o, running_o}, 3'b001);
            send_frame({1'b0, 7'(i)});
            send_frame({1'b1, i[0], p2});
            check("R4 word", buf_o, 32'({p0, p1, p2}));
            completion(cpl ? "R6 binary" : "R7 binary", cpl);
            rd_buf_i = 1'b1;
            cyc();
            rd_buf_i = 1'b0;
        end

        // R8 alpha start while running stops only
        do_start(1'b1, 1'b0, 1'b0);
        send_frame(8'hAA);
        check("R8 pre buf", buf_o, 32'h2A);
        do_start(1'b0, 1'b0, 1'b0);
        check("R8 stopped", running_o, 0);
        check("R8 buf kept", buf_o, 32'h2A);
        check("R8 flag kept", done_flag_o, 0);
        send_frame(8'h81);
        check("R11 after stop buf", buf_o, 32'h2A);
        // R8 binary start while running restarts
        do_start(1'b1, 1'b0, 1'b0);
        send_frame(8'h9F);
        do_start(1'b1, 1'b0, 1'b0);
        check("R8 binary restart buf", buf_o, 0);
        check("R8 binary restart running", running_o, 1);
        send_frame(8'h81); send_frame(8'h82); send_frame(8'h83);
        check("R8 fresh count word", buf_o, 32'h01083);
        check("R7 fresh irq", irq_o, 1);

        // R10 end of tape while waiting
        do_start(1'b1, 1'b1, 1'b1);
        send_frame(8'h81);
        eot_i = 1'b1; cyc(); eot_i = 1'b0;
        check("R10 release", hold_release_o, 1);
        check("R10 stopped", running_o, 0);
        check("R10 no restart", restart_o, 0);
        cyc();
        check("R10 pulse one cycle", hold_release_o, 0);
        do_start(1'b0, 1'b0, 1'b0);
        eot_i = 1'b1; cyc(); eot_i = 1'b0;
        check("R10 no wait no release", hold_release_o, 0);
        check("R10 no wait stopped", running_o, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule